// File: doc/BRIEF.md
# Interleaved Address Generator for Contention-Free Turbo Permutations

This block computes turbo interleaver addresses one per clock, without an address table. It supports two permutation families. The quadratic permutation is x -> (f2·x² + f1·x) mod N. The almost-regular permutation is x -> (P0·x + Q(x mod 4)) mod N, which also swaps the two bits of every odd couple. Both families run on the same two modular accumulators. Each accumulator adds two values that are both below N, subtracts N, and uses the sign of that difference to choose the reduced sum. The design has no multiplier, no divider and no memory.

Software or a parameter sequencer works out the start values for a chosen start index x0 and presents them with a one-cycle `start` pulse. The block takes these at that edge:

- the block length, up to 6144;
- the mode;
- the step: 2·f2 mod N for the quadratic mode, P0 for the regular mode;
- the first address-side value and the first increment;
- in the regular mode, the three offset terms P1..P3.

In the regular mode the four offsets are reduced modulo N at that same edge. After `start`, each clock cycle with `enable` high produces the next address, until N addresses have been produced. Several copies of the block, each started at a different x0, feed parallel sub-block decoders.

Top module: `ilv_addr_gen`

## Requirements
- R1: While `rst` is high, `addr_out` is 0 and `addr_valid` and `swap_out` are 0.
- R2: With `perm_mode`=0 (quadratic), the k-th valid address after a start with index x0 equals (f2·x² + f1·x) mod N, where x = x0+k. This holds when `init_pos` = that value at x0, `init_inc` = (2·f2·x0 + f1 + f2) mod N, and `step` = 2·f2 mod N.
- R3: Every valid address is below the block length N captured at start.
- R4: With `perm_mode`=1 (regular), the k-th valid address equals (P0·x + Q) mod N, where x = x0+k and `init_pos` = P0·x0 mod N, `step` = P0. Q is chosen by x mod 4: 1 for 0, 1+N/2+P1 for 1, 1+P2 for 2, 1+N/2+P3 for 3.
- R5: `swap_out` is 1 with a valid address exactly when the mode is regular and x is odd. It is 0 in the quadratic mode and whenever `addr_valid` is 0.
- R6: `addr_valid` is 0 in the cycle after `start`. Each enabled cycle produces one valid address one cycle later. Exactly N valid addresses follow a start, then `addr_valid` stays 0.
- R7: A cycle with `enable` low produces no valid address and does not advance the sequence. The next enabled cycle continues with the next index.
- R8: A start at a nonzero x0 gives the same address sequence as indices x0, x0+1, … of the full permutation, and it continues past N−1 with the indices taken modulo N.
- R9: A `start` during a run abandons that run. It takes the new mode, length and values, and the count starts again at N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load pulse for configuration and start values |
| enable | input | 1 | Produce the next address this cycle |
| perm_mode | input | 1 | 0 quadratic, 1 regular with couple swap |
| blk_len | input | 13 | Block length N, 2..6144 |
| x_start | input | 13 | Start index x0 (its two low bits set the phase) |
| init_pos | input | 13 | First address-side accumulator value |
| init_inc | input | 13 | First increment (quadratic mode) |
| step | input | 13 | Increment step: 2·f2 mod N or P0 |
| arp_p1 | input | 13 | Offset term P1, below N |
| arp_p2 | input | 13 | Offset term P2, below N |
| arp_p3 | input | 13 | Offset term P3, below N |
| addr_out | output | 13 | Interleaved address |
| addr_valid | output | 1 | Address is valid this cycle |
| swap_out | output | 1 | Swap the two bits of this couple |

## Verification
Every result of this block is registered once. The address for an index appears on `addr_out`, with `addr_valid` and `swap_out`, one cycle after the clock edge where `enable` was seen high. A `start` edge shows as `addr_valid` low in the next cycle. The bench model updates on the same rising edge the design uses: it advances its own index counter only on enabled edges and latches its configuration only at a start edge. All three outputs are compared against the model at the following falling edge, which keeps the checks exactly one register stage behind the stimulus. Runs with `enable` gaps and a restart in the middle of a run show that pauses and restarts shift the expected values by the correct number of cycles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int ILV_AW     = 13;
    localparam int ILV_PHASES = 4;

    typedef enum logic {
        PERM_QUAD = 1'b0,
        PERM_REG  = 1'b1
    } perm_mode_e;

    // offsets whose index is odd carry the half-block term
    function automatic logic phase_has_half(input int k);
        return (k % 2) == 1;
    endfunction

endpackage

// File: rtl/ilv_acc_unit.sv
module ilv_acc_unit #(
    parameter int AW = ilv_pkg::ILV_AW
) (
    input  logic [AW-1:0] opa,
    input  logic [AW-1:0] opb,
    input  logic [AW-1:0] modulus,
    output logic [AW-1:0] result
);
    logic [AW:0]   raw_sum;
    logic [AW+1:0] reduced;

    always_comb begin
        raw_sum = {1'b0, opa} + {1'b0, opb};
        reduced = {1'b0, raw_sum} - {2'b00, modulus};
        result  = reduced[AW+1] ? raw_sum[AW-1:0] : reduced[AW-1:0];
    end
endmodule

// File: rtl/ilv_offset_table.sv
module ilv_offset_table #(
    parameter int AW     = ilv_pkg::ILV_AW,
    parameter int PHASES = ilv_pkg::ILV_PHASES,
    localparam int PW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] n_len,
    input  logic [AW-1:0] p1,
    input  logic [AW-1:0] p2,
    input  logic [AW-1:0] p3,
    input  logic [PW-1:0] sel,
    output logic [AW-1:0] q_out
);
    logic [AW-1:0] term   [PHASES];
    logic [AW-1:0] stage1 [PHASES];
    logic [AW-1:0] stage2 [PHASES];
    logic [AW-1:0] q_reg  [PHASES];
    logic [AW-1:0] half_n;
    logic [AW-1:0] one_v;

    assign half_n  = n_len >> 1;
    assign one_v   = {{(AW-1){1'b0}}, 1'b1};
    assign term[0] = '0;
    assign term[1] = p1;
    assign term[2] = p2;
    assign term[3] = p3;

    for (genvar k = 0; k < PHASES; k++) begin : g_ofs
        logic [AW-1:0] half_term;
        assign half_term = ilv_pkg::phase_has_half(k) ? half_n : '0;

        ilv_acc_unit #(.AW(AW)) u_first (
            .opa(one_v), .opb(half_term), .modulus(n_len), .result(stage1[k])
        );
        ilv_acc_unit #(.AW(AW)) u_second (
            .opa(stage1[k]), .opb(term[k]), .modulus(n_len), .result(stage2[k])
        );

        always_ff @(posedge clk) begin
            if (rst)       q_reg[k] <= '0;
            else if (load) q_reg[k] <= stage2[k];
        end
    end

    assign q_out = q_reg[sel];
endmodule

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl #(
    parameter int AW     = ilv_pkg::ILV_AW,
    parameter int PHASES = ilv_pkg::ILV_PHASES,
    localparam int PW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          enable,
    input  logic [AW-1:0] run_len,
    input  logic [PW-1:0] phase_init,
    output logic          emit,
    output logic [PW-1:0] phase
);
    logic [AW-1:0] remaining;

    assign emit = enable && !start && (remaining != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            phase     <= '0;
        end else if (start) begin
            remaining <= run_len;
            phase     <= phase_init;
        end else if (emit) begin
            remaining <= remaining - 1'b1;
            phase     <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
    parameter int AW     = ilv_pkg::ILV_AW,
    parameter int PHASES = ilv_pkg::ILV_PHASES,
    localparam int PW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          enable,
    input  logic          perm_mode,
    input  logic [AW-1:0] blk_len,
    input  logic [AW-1:0] x_start,
    input  logic [AW-1:0] init_pos,
    input  logic [AW-1:0] init_inc,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] arp_p1,
    input  logic [AW-1:0] arp_p2,
    input  logic [AW-1:0] arp_p3,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid,
    output logic          swap_out
);
    import ilv_pkg::*;

    perm_mode_e    mode_q;
    logic [AW-1:0] len_q;
    logic [AW-1:0] step_q;
    logic [AW-1:0] acc_a;
    logic [AW-1:0] acc_b;
    logic [AW-1:0] q_sel;
    logic [AW-1:0] u0_b, u0_y;
    logic [AW-1:0] u1_a, u1_b, u1_y;
    logic          emit;
    logic [PW-1:0] phase;
    logic          is_reg;

    assign is_reg = (mode_q == PERM_REG);

    ilv_seq_ctrl #(.AW(AW), .PHASES(PHASES)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .enable(enable),
        .run_len(blk_len), .phase_init(x_start[PW-1:0]),
        .emit(emit), .phase(phase)
    );

    ilv_offset_table #(.AW(AW), .PHASES(PHASES)) u_ofs (
        .clk(clk), .rst(rst), .load(start), .n_len(blk_len),
        .p1(arp_p1), .p2(arp_p2), .p3(arp_p3),
        .sel(phase), .q_out(q_sel)
    );

    // unit 0: next address-side value (next position, or next P0 multiple)
    assign u0_b = is_reg ? step_q : acc_b;
    ilv_acc_unit #(.AW(AW)) u_acc0 (
        .opa(acc_a), .opb(u0_b), .modulus(len_q), .result(u0_y)
    );

    // unit 1: next increment (quadratic) or offset address (regular)
    assign u1_a = is_reg ? acc_a : acc_b;
    assign u1_b = is_reg ? q_sel : step_q;
    ilv_acc_unit #(.AW(AW)) u_acc1 (
        .opa(u1_a), .opb(u1_b), .modulus(len_q), .result(u1_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= PERM_QUAD;
            len_q      <= '0;
            step_q     <= '0;
            acc_a      <= '0;
            acc_b      <= '0;
            addr_out   <= '0;
            addr_valid <= 1'b0;
            swap_out   <= 1'b0;
        end else if (start) begin
            mode_q     <= perm_mode_e'(perm_mode);
            len_q      <= blk_len;
            step_q     <= step;
            acc_a      <= init_pos;
            acc_b      <= init_inc;
            addr_valid <= 1'b0;
            swap_out   <= 1'b0;
        end else if (emit) begin
            addr_out   <= is_reg ? u1_y : acc_a;
            acc_a      <= u0_y;
            if (!is_reg) acc_b <= u1_y;
            addr_valid <= 1'b1;
            swap_out   <= is_reg & phase[0];
        end else begin
            addr_valid <= 1'b0;
            swap_out   <= 1'b0;
        end
    end
endmodule

// File: rtl/ilv_addr_gen_checker.sv
module ilv_addr_gen_checker #(
    parameter int AW = ilv_pkg::ILV_AW
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          enable,
    input logic          cfg_reg,
    input logic [AW-1:0] cfg_len,
    input logic [AW-1:0] addr_out,
    input logic          addr_valid,
    input logic          swap_out
);
    logic [AW:0] seen;

    always_ff @(posedge clk) begin
        if (rst || start)    seen <= '0;
        else if (addr_valid) seen <= seen + 1'b1;
    end

    assert_addr_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (addr_out < cfg_len));

    assert_swap_reg_only_R5: assert property (@(posedge clk) disable iff (rst)
        swap_out |-> (addr_valid && cfg_reg));

    assert_swap_alternates_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && $past(addr_valid) && cfg_reg) |-> (swap_out != $past(swap_out)));

    assert_start_clears_valid_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !addr_valid);

    assert_run_length_R6: assert property (@(posedge clk) disable iff (rst)
        seen <= {1'b0, cfg_len});

    assert_valid_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> ($past(enable) && !$past(start)));
endmodule

bind ilv_addr_gen ilv_addr_gen_checker #(.AW(AW)) u_ilv_chk (
    .clk(clk), .rst(rst), .start(start), .enable(enable),
    .cfg_reg(is_reg), .cfg_len(len_q),
    .addr_out(addr_out), .addr_valid(addr_valid), .swap_out(swap_out)
);

// File: tb/ilv_addr_gen_bench.sv
`timescale 1ns/1ps
module ilv_addr_gen_bench;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          enable = 1'b0;
    logic          perm_mode = 1'b0;
    logic [AW-1:0] blk_len = '0, x_start = '0, init_pos = '0, init_inc = '0, step = '0;
    logic [AW-1:0] arp_p1 = '0, arp_p2 = '0, arp_p3 = '0;
    logic [AW-1:0] addr_out;
    logic          addr_valid, swap_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    done     = 0;
    bit    armed    = 0;
    string phase_tag = "R6";
    longint tb_f1 = 0, tb_f2 = 0;

    // reference model state
    bit     m_valid = 0, m_swap = 0, m_reg = 0;
    longint m_x = 0, m_rem = 0, m_n = 1, m_f1 = 0, m_f2 = 0, m_p0 = 0;
    longint m_q[4];
    longint m_addr = 0;

    always #2.5 clk = ~clk;

    ilv_addr_gen u_ilv_addr_gen (
        .clk(clk), .rst(rst), .start(start), .enable(enable), .perm_mode(perm_mode),
        .blk_len(blk_len), .x_start(x_start), .init_pos(init_pos), .init_inc(init_inc),
        .step(step), .arp_p1(arp_p1), .arp_p2(arp_p2), .arp_p3(arp_p3),
        .addr_out(addr_out), .addr_valid(addr_valid), .swap_out(swap_out)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, phase_tag, $time, act, exp);
        end
    endtask

    // behavioural model, updated on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_swap = 0; m_rem = 0;
        end else if (start) begin
            m_reg = perm_mode; m_n = blk_len; m_rem = blk_len; m_x = x_start;
            m_p0 = step; m_f1 = tb_f1; m_f2 = tb_f2;
            m_q[0] = 1 % m_n;
            m_q[1] = (1 + m_n / 2 + arp_p1) % m_n;
            m_q[2] = (1 + arp_p2) % m_n;
            m_q[3] = (1 + m_n / 2 + arp_p3) % m_n;
            m_valid = 0; m_swap = 0;
        end else if (enable && m_rem > 0) begin
            if (m_reg) m_addr = (m_p0 * m_x + m_q[m_x % 4]) % m_n;
            else       m_addr = (m_f2 * m_x * m_x + m_f1 * m_x) % m_n;
            m_valid = 1;
            m_swap  = m_reg && (m_x % 2 == 1);
            m_x++; m_rem--;
        end else begin
            m_valid = 0; m_swap = 0;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst && armed && !done) begin
            check("R6", addr_valid, m_valid);
            check("R5", swap_out, m_swap);
            if (m_valid) begin
                check(m_reg ? "R4" : "R2", addr_out, m_addr);
                check("R3", (addr_out < m_n) ? 1 : 0, 1);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
            report();
        end
    end

    task automatic start_quad(input int n, input int f1, input int f2, input int x0);
        @(negedge clk);
        tb_f1 = f1; tb_f2 = f2;
        perm_mode = 1'b0;
        blk_len   = AW'(n);
        x_start   = AW'(x0);
        init_pos  = AW'((longint'(f2) * x0 * x0 + longint'(f1) * x0) % n);
        init_inc  = AW'((2 * longint'(f2) * x0 + f1 + f2) % n);
        step      = AW'((2 * f2) % n);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic start_reg(input int n, input int p0, input int p1, input int p2,
                             input int p3, input int x0);
        @(negedge clk);
        perm_mode = 1'b1;
        blk_len   = AW'(n);
        x_start   = AW'(x0);
        init_pos  = AW'((longint'(p0) * x0) % n);
        init_inc  = '0;
        step      = AW'(p0);
        arp_p1    = AW'(p1); arp_p2 = AW'(p2); arp_p3 = AW'(p3);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic run(input int n_cyc, input int gap_every);
        for (int i = 0; i < n_cyc; i++) begin
            enable = (gap_every == 0) ? 1'b1 : ((i % gap_every) != gap_every - 1);
            @(negedge clk);
        end
        enable = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", addr_out, 0);
        check("R1", addr_valid, 0);
        check("R1", swap_out, 0);
        @(negedge clk);
        rst = 1'b0;
        armed = 1;

        // R2, R6: quadratic full run from x0 = 0, then idle past the end
        phase_tag = "R6";
        start_quad(40, 3, 10, 0);
        run(50, 0);

        // R8: large block started in the middle, wraps past N-1
        phase_tag = "R8";
        start_quad(6144, 263, 480, 3000);
        run(6150, 0);

        // R4, R5, R7: regular mode with enable gaps
        phase_tag = "R7";
        start_reg(48, 5, 10, 20, 30, 0);
        run(80, 3);

        // R9: regular run at odd x0, abandoned by a quadratic restart
        phase_tag = "R9";
        start_reg(240, 11, 4, 8, 12, 7);
        run(30, 0);
        enable = 1'b1;
        start_quad(40, 3, 10, 5);
        run(45, 0);

        // R4: larger regular block, full run
        phase_tag = "R4";
        start_reg(2400, 73, 1100, 37, 900, 1);
        run(2410, 5);

        repeat (3) @(negedge clk);
        done = 1;
        report();
    end
endmodule